// File: doc/BRIEF.md
# Paired Predicate Register File

This block stores the one-bit predicates that decide whether an issued operation is allowed to take effect. A compare unit outside the block produces a single condition bit and names two destination predicates. In one cycle the first destination takes the condition and the second takes its inverse. Code can therefore guard two alternative operations with opposite predicates, place both in the same issue group, and let only one of them survive, where it would otherwise need a branch.

Each guard read port receives a request and a predicate index from an issuing operation. The port answers with a commit bit, which is high only when the request is present and the named predicate is true. Entry 0 is fixed at true, so an operation guarded by it always commits. A compare that names the same entry for both destinations is rejected and flagged. By default a guard read in the same cycle as a compare sees the value being written. A parameter can select reads of the stored value only.

Top module: `pred_pair_rf`

## Requirements
- R1: There are NUM_PRED (default 64) one-bit entries. A synchronous reset clears entries 1 to NUM_PRED-1 to 0, so a requested guard on any of them returns commit 0 after reset.
- R2: Entry 0 always reads as 1. A requested guard naming index 0 always commits.
- R3: A compare with cmp_valid=1 and distinct destinations writes cmp_cond to the entry at cmp_dst_t and ~cmp_cond to the entry at cmp_dst_f. Both values are visible from the next cycle.
- R4: A destination index of 0 has no effect on entry 0. The other destination of that compare is still written.
- R5: When cmp_valid=1 and cmp_dst_t equals cmp_dst_f, cmp_err is 1 in that same cycle and no entry changes. In every other cycle cmp_err is 0.
- R6: grd_commit[g] equals grd_req[g] AND the predicate named by grd_idx[g]. With grd_req[g]=0 the commit is 0.
- R7: With the default write-first mode, a guard that reads a destination of an accepted compare in the same cycle returns the value being written.
- R8: An entry that no accepted compare names keeps its value.
- R9: The guard ports work independently. Two requested guards on the two destinations of one compare give exactly one commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | A compare result is present this cycle |
| cmp_dst_t | input | IDX_W | Entry that receives the condition |
| cmp_dst_f | input | IDX_W | Entry that receives the inverted condition |
| cmp_cond | input | 1 | Condition bit from the comparator |
| cmp_err | output | 1 | Compare rejected because both destinations are the same entry |
| grd_req | input | NUM_GUARD | Per-port guard request |
| grd_idx | input | NUM_GUARD x IDX_W | Per-port guard predicate index |
| grd_commit | output | NUM_GUARD | Per-port permission for the operation to take effect |

## Verification
The assertions check the following on every cycle: both destinations of an accepted compare hold the right values one cycle later, a rejected compare is flagged and changes nothing, the stored vector holds still when no compare is present, index 0 always commits, and a missing request never commits. Three behaviours need the bench's scenarios because they depend on a history of writes. These are same-cycle bypass on both ports, a write to entry 0 that leaves the other destination updated, and values held across long stretches of random traffic.

// File: rtl/pred_pkg.sv
package pred_pkg;
   localparam int DEF_NUM_PRED  = 64;
   localparam int DEF_NUM_GUARD = 2;

   typedef enum logic {
      RD_STORED      = 1'b0,
      RD_WRITE_FIRST = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/pred_wdec.sv
module pred_wdec #(
   parameter int NUM_PRED = pred_pkg::DEF_NUM_PRED,
   localparam int IDX_W   = $clog2(NUM_PRED)
) (
   input  logic                 cmp_valid,
   input  logic [IDX_W-1:0]     dst_t,
   input  logic [IDX_W-1:0]     dst_f,
   input  logic                 cond,
   output logic                 reject,
   output logic                 accept,
   output logic [NUM_PRED-1:1]  wen,
   output logic [NUM_PRED-1:1]  wdat
);
   assign reject = cmp_valid && (dst_t == dst_f);
   assign accept = cmp_valid && (dst_t != dst_f);

   for (genvar i = 1; i < NUM_PRED; i++) begin : g_ent
      logic hit_t, hit_f;
      assign hit_t   = (dst_t == IDX_W'(i));
      assign hit_f   = (dst_f == IDX_W'(i));
      assign wen[i]  = accept && (hit_t || hit_f);
      assign wdat[i] = hit_t ? cond : ~cond;
   end
endmodule

// File: rtl/pred_store.sv
module pred_store #(
   parameter int NUM_PRED = pred_pkg::DEF_NUM_PRED
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_PRED-1:1]  wen,
   input  logic [NUM_PRED-1:1]  wdat,
   output logic [NUM_PRED-1:0]  pvec
);
   assign pvec[0] = 1'b1;

   for (genvar i = 1; i < NUM_PRED; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
         if (rst)         q <= 1'b0;
         else if (wen[i]) q <= wdat[i];
      end
      assign pvec[i] = q;
   end

   // R2: entry 0 never leaves true
   p_zero_true_r2: assert property (@(posedge clk) disable iff (rst) pvec[0] == 1'b1);
endmodule

// File: rtl/pred_rdport.sv
module pred_rdport #(
   parameter int                NUM_PRED = pred_pkg::DEF_NUM_PRED,
   parameter pred_pkg::rd_mode_e RD_MODE = pred_pkg::RD_WRITE_FIRST,
   localparam int               IDX_W    = $clog2(NUM_PRED)
) (
   input  logic [NUM_PRED-1:0]  pvec,
   input  logic                 req,
   input  logic [IDX_W-1:0]     idx,
   input  logic                 wr_accept,
   input  logic [IDX_W-1:0]     dst_t,
   input  logic [IDX_W-1:0]     dst_f,
   input  logic                 cond,
   output logic                 commit
);
   logic stored;
   logic pred;

   always_comb begin
      stored = 1'b0;
      for (int i = 0; i < NUM_PRED; i++)
         if (idx == IDX_W'(i)) stored = pvec[i];
   end

   if (RD_MODE == pred_pkg::RD_WRITE_FIRST) begin : g_bypass
      always_comb begin
         pred = stored;
         if (idx == '0)                           pred = 1'b1;
         else if (wr_accept && (idx == dst_t))    pred = cond;
         else if (wr_accept && (idx == dst_f))    pred = ~cond;
      end
   end else begin : g_stored
      logic unused_wr;
      assign unused_wr = ^{wr_accept, dst_t, dst_f, cond};
      assign pred = stored;
   end

   assign commit = req && pred;
endmodule

// File: rtl/pred_pair_rf.sv
module pred_pair_rf #(
   parameter int                 NUM_PRED  = pred_pkg::DEF_NUM_PRED,
   parameter int                 NUM_GUARD = pred_pkg::DEF_NUM_GUARD,
   parameter pred_pkg::rd_mode_e RD_MODE   = pred_pkg::RD_WRITE_FIRST,
   localparam int                IDX_W     = $clog2(NUM_PRED)
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            cmp_valid,
   input  logic [IDX_W-1:0]                cmp_dst_t,
   input  logic [IDX_W-1:0]                cmp_dst_f,
   input  logic                            cmp_cond,
   output logic                            cmp_err,
   input  logic [NUM_GUARD-1:0]            grd_req,
   input  logic [NUM_GUARD-1:0][IDX_W-1:0] grd_idx,
   output logic [NUM_GUARD-1:0]            grd_commit
);
   if (NUM_PRED < 2)        begin : g_chk_n  $error("NUM_PRED must be at least 2"); end
   if (NUM_PRED > 4096)     begin : g_chk_m  $error("NUM_PRED too large"); end
   if (NUM_GUARD < 1)       begin : g_chk_g  $error("NUM_GUARD must be at least 1"); end

   logic                wr_accept;
   logic [NUM_PRED-1:1] wen, wdat;
   logic [NUM_PRED-1:0] pvec;

   pred_wdec #(.NUM_PRED(NUM_PRED)) u_wdec (
      .cmp_valid (cmp_valid),
      .dst_t     (cmp_dst_t),
      .dst_f     (cmp_dst_f),
      .cond      (cmp_cond),
      .reject    (cmp_err),
      .accept    (wr_accept),
      .wen       (wen),
      .wdat      (wdat)
   );

   pred_store #(.NUM_PRED(NUM_PRED)) u_store (
      .clk  (clk),
      .rst  (rst),
      .wen  (wen),
      .wdat (wdat),
      .pvec (pvec)
   );

   for (genvar g = 0; g < NUM_GUARD; g++) begin : g_port
      pred_rdport #(.NUM_PRED(NUM_PRED), .RD_MODE(RD_MODE)) u_rd (
         .pvec      (pvec),
         .req       (grd_req[g]),
         .idx       (grd_idx[g]),
         .wr_accept (wr_accept),
         .dst_t     (cmp_dst_t),
         .dst_f     (cmp_dst_f),
         .cond      (cmp_cond),
         .commit    (grd_commit[g])
      );

      // R6: no request, no commit
      p_no_req_r6: assert property (@(posedge clk) disable iff (rst)
         !grd_req[g] |-> !grd_commit[g]);
      // R2: guard on entry 0 always commits
      p_zero_commit_r2: assert property (@(posedge clk) disable iff (rst)
         (grd_req[g] && grd_idx[g] == '0) |-> grd_commit[g]);
   end

   // R1: reset leaves only entry 0 set
   p_reset_clear_r1: assert property (@(posedge clk)
      $past(rst) |-> pvec == NUM_PRED'(1));
   // R3: first destination takes the condition
   p_first_dst_r3: assert property (@(posedge clk) disable iff (rst)
      (cmp_valid && cmp_dst_t != cmp_dst_f && cmp_dst_t != '0)
      |=> pvec[$past(cmp_dst_t)] == $past(cmp_cond));
   // R3: second destination takes the inverse
   p_second_dst_r3: assert property (@(posedge clk) disable iff (rst)
      (cmp_valid && cmp_dst_t != cmp_dst_f && cmp_dst_f != '0)
      |=> pvec[$past(cmp_dst_f)] == !$past(cmp_cond));
   // R5: a same-entry compare changes nothing
   p_reject_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (cmp_valid && cmp_dst_t == cmp_dst_f) |=> pvec == $past(pvec));
   // R5: flag only on a same-entry compare
   p_err_flag_r5: assert property (@(posedge clk) disable iff (rst)
      cmp_err == (cmp_valid && cmp_dst_t == cmp_dst_f));
   // R8: no compare, no change
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !cmp_valid |=> pvec == $past(pvec));
endmodule

// File: tb/sim_pred_pair_rf.sv
module sim_pred_pair_rf;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 64;
   localparam int IW = 6;

   logic          clk = 1'b0;
   logic          rst;
   logic          cmp_valid, cmp_cond, cmp_err;
   logic [IW-1:0] cmp_dst_t, cmp_dst_f;
   logic [1:0]    grd_req, grd_commit;
   logic [1:0][IW-1:0] grd_idx;

   int checks = 0;
   int errors = 0;
   bit model [NP];

   always #(CLK_PERIOD/2) clk = ~clk;

   pred_pair_rf u0 (
      .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_dst_t(cmp_dst_t),
      .cmp_dst_f(cmp_dst_f), .cmp_cond(cmp_cond), .cmp_err(cmp_err),
      .grd_req(grd_req), .grd_idx(grd_idx), .grd_commit(grd_commit)
   );

   function automatic bit exp_commit(bit req, int idx, bit v, int t, int f, bit c);
      if (!req) return 1'b0;
      if (idx == 0) return 1'b1;
      if (v && t != f) begin
         if (idx == t) return c;
         if (idx == f) return !c;
      end
      return model[idx];
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic cyc(string tag, bit v, int t, int f, bit c,
                      bit r0, int i0, bit r1, int i1);
      @(negedge clk);
      cmp_valid = v; cmp_dst_t = IW'(t); cmp_dst_f = IW'(f); cmp_cond = c;
      grd_req = {r1, r0}; grd_idx[0] = IW'(i0); grd_idx[1] = IW'(i1);
      #1;
      chk({tag, " R5 err"}, cmp_err, v && t == f);
      chk({tag, " commit0"}, grd_commit[0], exp_commit(r0, i0, v, t, f, c));
      chk({tag, " commit1"}, grd_commit[1], exp_commit(r1, i1, v, t, f, c));
      @(posedge clk);
      if (v && t != f) begin
         if (t != 0) model[t] = c;
         if (f != 0) model[f] = !c;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed1234));
      rst = 1'b1; cmp_valid = 0; cmp_dst_t = 0; cmp_dst_f = 0; cmp_cond = 0;
      grd_req = 0; grd_idx = '0;
      for (int i = 0; i < NP; i++) model[i] = (i == 0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      cyc("R1 reset", 0, 0, 0, 0, 1, 5, 1, 63);
      cyc("R2 zero",  0, 0, 0, 0, 1, 0, 0, 0);
      cyc("R7 bypass", 1, 3, 4, 1, 1, 3, 1, 4);
      cyc("R3 R9 pair", 0, 0, 0, 0, 1, 3, 1, 4);
      cyc("R6 noreq", 0, 0, 0, 0, 0, 3, 0, 0);
      cyc("R4 zero dst", 1, 0, 7, 0, 1, 0, 1, 7);
      cyc("R4 after", 0, 0, 0, 0, 1, 0, 1, 7);
      cyc("R4 zero f", 1, 7, 0, 0, 1, 0, 1, 7);
      cyc("R4 after2", 0, 0, 0, 0, 1, 0, 1, 7);
      cyc("R5 reject", 1, 9, 9, 1, 1, 9, 1, 3);
      cyc("R5 after", 0, 0, 0, 0, 1, 9, 1, 4);
      cyc("R5 zero same", 1, 0, 0, 0, 1, 0, 1, 0);
      repeat (4) cyc("R8 idle", 0, 0, 0, 0, 1, 3, 1, 4);
      cyc("R9 flip", 1, 4, 3, 1, 1, 3, 1, 4);
      cyc("R9 flip after", 0, 0, 0, 0, 1, 3, 1, 4);
      chk("R3 model 63 clear", model[63], 1'b0);

      for (int n = 0; n < 3000; n++) begin
         int t = $urandom_range(0, NP-1);
         int f = ($urandom_range(0, 15) == 0) ? t : $urandom_range(0, NP-1);
         int i0 = ($urandom_range(0, 3) == 0) ? t : $urandom_range(0, NP-1);
         int i1 = ($urandom_range(0, 3) == 0) ? f : $urandom_range(0, NP-1);
         cyc("R3 R6 R7 R8 random", $urandom_range(0, 1) == 1, t, f,
             $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0, i0,
             $urandom_range(0, 3) != 0, i1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule